// File: doc/BRIEF.md
# Fuzzy Rule Base Expander

This block loads one compact fuzzy rule at a time and writes its consequents into the rule memories. Each memory location is addressed by one combination of input term indexes. A rule carries four 3-bit antecedent term indexes and up to two consequent values. An index of zero marks an input that takes no part in the rule, a don't-care. The block expands every don't-care input over all seven term values, so a single reduced rule fills every location it covers. A rule with no antecedents at all fills the whole table with one consequent.

The control sequencer waits for a rule-ready strobe and captures the rule. It then classifies which inputs are present and either rejects the rule or sweeps the write address through every covered combination, one write per cycle. Last, it advances a rule-fetch pointer so that the next rule can be read. A setting for the number of active inputs pins the unused upper inputs to term 1, so those inputs are never swept. The same setting also decides whether certain presence patterns are allowed.

Top module: `rule_base_expander`

## Requirements
- R1: The write address is {term4, term3, term2, term1}, with term1 in bits 2:0 and term4 in bits 11:9. A rule whose four effective indexes are all non-zero produces exactly one write, at that address.
- R2: Each effective index of zero marks its input as absent. A rule with n absent inputs produces 7^n writes on consecutive cycles. Each absent field takes the values 1..7 and the lowest-numbered absent input steps fastest. Present fields keep their value throughout.
- R3: A rule with all four effective indexes zero produces 2401 writes. These cover every address whose four fields are each in 1..7, and all of them carry the same consequent.
- R4: Input k (k = 1..4) is used only when k is at most the input-count setting. An unused input takes the effective index 1, whatever its raw index.
- R5: A rule is rejected when inputs 1 and 2 are both absent and input 3 or input 4 is present while the input-count setting is below 3. It is also rejected when input 4 is the only present input and the setting is not 4. A rejected rule produces no write.
- R6: Each write carries the consequents captured with the rule. Output j's enable is active only when bit j of the captured consequent-valid mask is 1.
- R7: Every rule, accepted or rejected, advances the rule-fetch address by exactly 3, one step per cycle. At all other times the address holds.
- R8: Busy is high from the cycle after a rule is captured until its fetch update ends. A rule-ready strobe that arrives while busy is ignored. A one-cycle done pulse follows each rule.
- R9: After reset, busy, done and all write enables are low and the fetch address is 0.
- R10: When a rule is captured at clock edge E, its first write is presented in the cycle after edge E+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rule_avail_i | input | 1 | A new rule is ready on the inputs |
| term_idx_i | input | 12 | Four 3-bit term indexes, input 1 in bits 2:0 |
| num_inputs_i | input | 3 | Number of active inputs (1..4) |
| cons_i | input | 16 | Two 8-bit consequents, output 0 in bits 7:0 |
| cons_vld_i | input | 2 | Per-output consequent valid mask |
| wr_en_o | output | 2 | Write enable per consequent memory |
| wr_addr_o | output | 12 | Rule memory write address |
| wr_data_o | output | 16 | Consequent data being written |
| fetch_addr_o | output | 12 | Rule-fetch address counter |
| busy_o | output | 1 | A rule is being processed |
| rule_done_o | output | 1 | One-cycle pulse when a rule finishes |

## Verification
The assertions check the following on every cycle:
- every written address field lies in 1..7;
- back-to-back writes never repeat an address and keep the same data;
- nothing is written while idle;
- the fetch address only moves in single steps, and never while idle;
- busy starts only after a strobe;
- done is a single-cycle pulse.

Only the bench's scenarios can show the rest. These are the exact visiting order of the sweep, the number of writes for each presence pattern, and the effect of the input-count setting on pinning and rejection. They also include the first-write latency and that a strobe arriving mid-sweep leaves the rule being processed untouched.

// File: rtl/rbx_pkg.sv
package rbx_pkg;
  localparam int RBX_N_IN  = 4;
  localparam int RBX_IDX_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DECODE = 2'd1,
    ST_SWEEP  = 2'd2,
    ST_UPDATE = 2'd3
  } rbx_state_e;
endpackage

// File: rtl/rbx_presence.sv
// Derives effective indexes, the absent mask and the rejection flag
// from the captured rule and the input-count setting.
module rbx_presence #(
  parameter int IDX_W = rbx_pkg::RBX_IDX_W,
  parameter int N_IN  = rbx_pkg::RBX_N_IN,
  parameter int NUM_W = 3
) (
  input  logic [N_IN*IDX_W-1:0] idx_i,
  input  logic [NUM_W-1:0]      num_i,
  output logic [N_IN*IDX_W-1:0] eff_o,
  output logic [N_IN-1:0]       absent_o,
  output logic                  reject_o
);
  localparam logic [IDX_W-1:0] PIN_TERM = IDX_W'(1);

  logic [N_IN-1:0] present;

  for (genvar k = 0; k < N_IN; k++) begin : g_in
    logic [IDX_W-1:0] raw;
    logic             used;
    assign raw  = idx_i[k*IDX_W +: IDX_W];
    assign used = (NUM_W'(k) < num_i);
    assign eff_o[k*IDX_W +: IDX_W] = used ? raw : PIN_TERM;
    assign absent_o[k] = ~|eff_o[k*IDX_W +: IDX_W];
    assign present[k]  = ~absent_o[k];
  end

  // Rejection rules reference inputs 1..4 (bits 0..3).
  logic low_pair_absent, upper_present, count_lt3, only_top, count_not4;
  assign low_pair_absent = absent_o[0] & absent_o[1];
  assign upper_present   = present[2] | present[3];
  assign count_lt3       = (num_i < NUM_W'(3));
  assign only_top        = (present[3:0] == 4'b1000);
  assign count_not4      = (num_i != NUM_W'(4));

  assign reject_o = (low_pair_absent & upper_present & count_lt3) |
                    (only_top & count_not4);
endmodule

// File: rtl/rbx_sweep.sv
// Mixed odometer over the absent fields: lowest absent field innermost,
// each absent field cycles 1..max, present fields hold their seed.
module rbx_sweep #(
  parameter int IDX_W = rbx_pkg::RBX_IDX_W,
  parameter int N_IN  = rbx_pkg::RBX_N_IN
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_i,
  input  logic                  step_i,
  input  logic [N_IN-1:0]       absent_i,
  input  logic [N_IN*IDX_W-1:0] seed_i,
  output logic [N_IN*IDX_W-1:0] cur_o,
  output logic                  last_o
);
  localparam logic [IDX_W-1:0] TERM_MAX   = '1;
  localparam logic [IDX_W-1:0] TERM_FIRST = IDX_W'(1);

  logic [N_IN:0] carry;
  assign carry[0] = 1'b1;

  for (genvar k = 0; k < N_IN; k++) begin : g_digit
    logic [IDX_W-1:0] cur_q;
    logic [IDX_W-1:0] nxt;
    logic [IDX_W-1:0] start;
    logic             at_max;

    assign at_max = (cur_q == TERM_MAX);
    assign start  = absent_i[k] ? TERM_FIRST : seed_i[k*IDX_W +: IDX_W];

    always_comb begin
      nxt = cur_q;
      if (absent_i[k] && carry[k]) begin
        nxt = at_max ? TERM_FIRST : cur_q + IDX_W'(1);
      end
    end

    assign carry[k+1] = carry[k] & (~absent_i[k] | at_max);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cur_q <= '0;
      end else if (load_i) begin
        cur_q <= start;
      end else if (step_i) begin
        cur_q <= nxt;
      end
    end

    assign cur_o[k*IDX_W +: IDX_W] = cur_q;
  end

  assign last_o = carry[N_IN];
endmodule

// File: rtl/rbx_ctrl.sv
// Rule sequencer: idle -> decode -> sweep (or skip) -> fetch update.
module rbx_ctrl #(
  parameter int FETCH_W    = 12,
  parameter int FETCH_STEP = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rule_avail_i,
  input  logic               reject_i,
  input  logic               last_i,
  output logic               capture_o,
  output logic               load_o,
  output logic               step_o,
  output logic               wr_active_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [FETCH_W-1:0] fetch_o
);
  import rbx_pkg::*;

  localparam int              CNT_W    = $clog2(FETCH_STEP + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FETCH_STEP - 1);

  rbx_state_e         state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FETCH_W-1:0] fetch_q, fetch_d;
  logic               done_q, done_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    fetch_d = fetch_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (rule_avail_i) state_d = ST_DECODE;
      end
      ST_DECODE: begin
        cnt_d   = '0;
        state_d = reject_i ? ST_UPDATE : ST_SWEEP;
      end
      ST_SWEEP: begin
        cnt_d = '0;
        if (last_i) state_d = ST_UPDATE;
      end
      ST_UPDATE: begin
        fetch_d = fetch_q + FETCH_W'(1);
        if (cnt_q == CNT_LAST) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      fetch_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      fetch_q <= fetch_d;
      done_q  <= done_d;
    end
  end

  assign capture_o   = (state_q == ST_IDLE) && rule_avail_i;
  assign load_o      = (state_q == ST_DECODE);
  assign step_o      = (state_q == ST_SWEEP) && !last_i;
  assign wr_active_o = (state_q == ST_SWEEP);
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign fetch_o     = fetch_q;
endmodule

// File: rtl/rule_base_expander.sv
module rule_base_expander #(
  parameter int IDX_W      = rbx_pkg::RBX_IDX_W,
  parameter int N_IN       = rbx_pkg::RBX_N_IN,
  parameter int NUM_W      = 3,
  parameter int DATA_W     = 8,
  parameter int N_OUT      = 2,
  parameter int FETCH_W    = 12,
  parameter int FETCH_STEP = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rule_avail_i,
  input  logic [N_IN*IDX_W-1:0]   term_idx_i,
  input  logic [NUM_W-1:0]        num_inputs_i,
  input  logic [N_OUT*DATA_W-1:0] cons_i,
  input  logic [N_OUT-1:0]        cons_vld_i,
  output logic [N_OUT-1:0]        wr_en_o,
  output logic [N_IN*IDX_W-1:0]   wr_addr_o,
  output logic [N_OUT*DATA_W-1:0] wr_data_o,
  output logic [FETCH_W-1:0]      fetch_addr_o,
  output logic                    busy_o,
  output logic                    rule_done_o
);
  localparam int ADDR_W = N_IN * IDX_W;
  localparam int CONS_W = N_OUT * DATA_W;

  logic              capture, load, step, wr_active, last, reject;
  logic [ADDR_W-1:0] idx_q, eff_idx, cur_addr;
  logic [NUM_W-1:0]  num_q;
  logic [CONS_W-1:0] cons_q;
  logic [N_OUT-1:0]  vld_q;
  logic [N_IN-1:0]   absent;

  // Rule capture registers, enabled only when idle and a rule is offered.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      num_q  <= '0;
      cons_q <= '0;
      vld_q  <= '0;
    end else if (capture) begin
      idx_q  <= term_idx_i;
      num_q  <= num_inputs_i;
      cons_q <= cons_i;
      vld_q  <= cons_vld_i;
    end
  end

  rbx_presence #(.IDX_W(IDX_W), .N_IN(N_IN), .NUM_W(NUM_W)) u_presence (
    .idx_i    (idx_q),
    .num_i    (num_q),
    .eff_o    (eff_idx),
    .absent_o (absent),
    .reject_o (reject)
  );

  rbx_sweep #(.IDX_W(IDX_W), .N_IN(N_IN)) u_sweep (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .step_i   (step),
    .absent_i (absent),
    .seed_i   (eff_idx),
    .cur_o    (cur_addr),
    .last_o   (last)
  );

  rbx_ctrl #(.FETCH_W(FETCH_W), .FETCH_STEP(FETCH_STEP)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .rule_avail_i (rule_avail_i),
    .reject_i     (reject),
    .last_i       (last),
    .capture_o    (capture),
    .load_o       (load),
    .step_o       (step),
    .wr_active_o  (wr_active),
    .busy_o       (busy_o),
    .done_o       (rule_done_o),
    .fetch_o      (fetch_addr_o)
  );

  assign wr_en_o   = {N_OUT{wr_active}} & vld_q;
  assign wr_addr_o = cur_addr;
  assign wr_data_o = cons_q;
endmodule

// File: rtl/rbx_checker.sv
module rbx_checker #(
  parameter int IDX_W   = 3,
  parameter int N_IN    = 4,
  parameter int DATA_W  = 8,
  parameter int N_OUT   = 2,
  parameter int FETCH_W = 12
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    rule_avail_i,
  input logic [N_OUT-1:0]        wr_en_o,
  input logic [N_IN*IDX_W-1:0]   wr_addr_o,
  input logic [N_OUT*DATA_W-1:0] wr_data_o,
  input logic [FETCH_W-1:0]      fetch_addr_o,
  input logic                    busy_o,
  input logic                    rule_done_o
);
  logic [N_IN-1:0] field_nz;
  for (genvar k = 0; k < N_IN; k++) begin : g_f
    assign field_nz[k] = |wr_addr_o[k*IDX_W +: IDX_W];
  end

  assert_field_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_en_o) |-> (&field_nz));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (wr_en_o == '0));

  assert_fetch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> $stable(fetch_addr_o));

  assert_fetch_unit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_addr_o != $past(fetch_addr_o)) |->
      (fetch_addr_o == $past(fetch_addr_o) + FETCH_W'(1)));

  assert_addr_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((|wr_en_o) && (|$past(wr_en_o))) |-> (wr_addr_o != $past(wr_addr_o)));

  assert_data_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|wr_en_o) && (|$past(wr_en_o))) |-> $stable(wr_data_o));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rule_done_o |=> !rule_done_o);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rule_done_o |-> !busy_o);

  assert_busy_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(rule_avail_i));
endmodule

bind rule_base_expander rbx_checker #(
  .IDX_W(IDX_W), .N_IN(N_IN), .DATA_W(DATA_W), .N_OUT(N_OUT), .FETCH_W(FETCH_W)
) u_rbx_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .rule_avail_i (rule_avail_i),
  .wr_en_o      (wr_en_o),
  .wr_addr_o    (wr_addr_o),
  .wr_data_o    (wr_data_o),
  .fetch_addr_o (fetch_addr_o),
  .busy_o       (busy_o),
  .rule_done_o  (rule_done_o)
);

// File: tb/rule_base_expander_tb.sv
`timescale 1ns/1ps
module rule_base_expander_tb;
  localparam int MAXW = 2401;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rule_avail_i;
  logic [11:0] term_idx_i;
  logic [2:0]  num_inputs_i;
  logic [15:0] cons_i;
  logic [1:0]  cons_vld_i;
  logic [1:0]  wr_en_o;
  logic [11:0] wr_addr_o;
  logic [15:0] wr_data_o;
  logic [11:0] fetch_addr_o;
  logic        busy_o;
  logic        rule_done_o;

  always #2.5 clk = ~clk;

  rule_base_expander u_dut (
    .clk(clk), .rst_n(rst_n), .rule_avail_i(rule_avail_i),
    .term_idx_i(term_idx_i), .num_inputs_i(num_inputs_i), .cons_i(cons_i),
    .cons_vld_i(cons_vld_i), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .fetch_addr_o(fetch_addr_o), .busy_o(busy_o),
    .rule_done_o(rule_done_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // write capture
  int          nw;
  logic [11:0] got_addr [MAXW];
  logic [15:0] got_data [MAXW];
  logic [1:0]  got_en   [MAXW];
  realtime     t_first, t_last;

  always @(negedge clk) begin
    if (|wr_en_o) begin
      if (nw < MAXW) begin
        got_addr[nw] = wr_addr_o;
        got_data[nw] = wr_data_o;
        got_en[nw]   = wr_en_o;
      end
      if (nw == 0) t_first = $realtime;
      t_last = $realtime;
      nw++;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // expected model
  logic [2:0] e_eff [4];
  logic [3:0] e_abs;
  bit         e_rej;
  int         e_cnt;

  task automatic model(input logic [11:0] idx, input logic [2:0] num);
    int nab = 0;
    for (int k = 0; k < 4; k++) begin
      e_eff[k] = (k < int'(num)) ? idx[k*3 +: 3] : 3'd1;
      e_abs[k] = (e_eff[k] == 3'd0);
      if (e_abs[k]) nab++;
    end
    e_rej = (e_abs[0] && e_abs[1] && (!e_abs[2] || !e_abs[3]) && num < 3) ||
            ((~e_abs) == 4'b1000 && num != 4);
    e_cnt = 1;
    for (int k = 0; k < nab; k++) e_cnt *= 7;
    if (e_rej) e_cnt = 0;
  endtask

  function automatic logic [11:0] exp_addr(input int j);
    logic [11:0] a;
    int r = j;
    for (int k = 0; k < 4; k++) begin
      if (e_abs[k]) begin
        a[k*3 +: 3] = 3'(r % 7 + 1);
        r = r / 7;
      end else begin
        a[k*3 +: 3] = e_eff[k];
      end
    end
    return a;
  endfunction

  task automatic run_rule(input logic [11:0] idx, input logic [2:0] num,
                          input logic [15:0] cons, input logic [1:0] vld,
                          input string tag_in, input bit glitch);
    string       tag;
    logic [11:0] f0;
    realtime     t0;
    int          bad, first_bad;
    model(idx, num);
    if (tag_in != "") tag = tag_in;
    else if (e_rej) tag = "R5";
    else if (e_abs == 4'hF) tag = "R3";
    else if (e_abs == 4'h0) tag = "R1";
    else tag = "R2";
    @(negedge clk);
    nw = 0;
    f0 = fetch_addr_o;
    t0 = $realtime;
    rule_avail_i = 1'b1;
    term_idx_i = idx; num_inputs_i = num; cons_i = cons; cons_vld_i = vld;
    if (glitch) begin
      fork
        begin
          repeat (20) @(negedge clk);
          rule_avail_i = 1'b1;
          term_idx_i = 12'hFFF; num_inputs_i = 3'd4;
          cons_i = ~cons; cons_vld_i = 2'b11;
          @(negedge clk);
          rule_avail_i = 1'b0;
        end
      join_none
    end
    @(negedge clk);
    rule_avail_i = 1'b0;
    do @(negedge clk); while (!rule_done_o);
    chk(nw == e_cnt, tag, "write count", nw, e_cnt);
    bad = 0; first_bad = -1;
    for (int j = 0; j < nw && j < MAXW; j++) begin
      if (got_addr[j] !== exp_addr(j) || got_data[j] !== cons || got_en[j] !== vld) begin
        if (first_bad < 0) first_bad = j;
        bad++;
      end
    end
    if (first_bad >= 0)
      chk(0, tag, "write addr (first bad entry)", got_addr[first_bad], exp_addr(first_bad));
    else
      chk(1, tag, "write sequence", 0, 0);
    if (glitch) chk(bad == 0, "R8", "mid-rule strobe corrupted writes", bad, 0);
    if (e_cnt > 0) begin
      chk(t_first == t0 + 10.0, "R10", "first write time (ps)",
          longint'((t_first - t0) * 1000), 10000);
      chk(t_last - t_first == (e_cnt - 1) * 5.0, "R2", "writes not consecutive",
          longint'((t_last - t_first) / 5.0), e_cnt - 1);
    end
    chk(fetch_addr_o == f0 + 12'd3, "R7", "fetch advance", fetch_addr_o, f0 + 12'd3);
    chk(!busy_o, "R8", "busy at done", busy_o, 0);
    @(negedge clk);
    chk(!rule_done_o, "R8", "done pulse width", rule_done_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; rule_avail_i = 1'b0; term_idx_i = '0;
    num_inputs_i = 3'd4; cons_i = '0; cons_vld_i = '0; nw = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !rule_done_o && wr_en_o == 0, "R9", "reset outputs",
        {busy_o, rule_done_o, wr_en_o}, 0);
    chk(fetch_addr_o == 0, "R9", "reset fetch", fetch_addr_o, 0);

    // directed corners
    run_rule({3'd7, 3'd3, 3'd5, 3'd2}, 3'd4, 16'hA55A, 2'b11, "R1", 0);
    run_rule({3'd4, 3'd0, 3'd6, 3'd0}, 3'd4, 16'h1234, 2'b11, "R2", 0);
    run_rule({3'd0, 3'd0, 3'd0, 3'd0}, 3'd4, 16'hBEEF, 2'b11, "R3", 0);
    run_rule({3'd5, 3'd6, 3'd0, 3'd0}, 3'd2, 16'h0F0F, 2'b11, "R5", 0);
    run_rule({3'd6, 3'd2, 3'd0, 3'd3}, 3'd2, 16'h2222, 2'b11, "R4", 0);
    run_rule({3'd0, 3'd5, 3'd0, 3'd0}, 3'd3, 16'h3333, 2'b11, "R4", 0);
    run_rule({3'd0, 3'd0, 3'd0, 3'd0}, 3'd3, 16'h4444, 2'b11, "R5", 0);
    run_rule({3'd3, 3'd0, 3'd0, 3'd0}, 3'd4, 16'h5555, 2'b10, "R6", 0);
    run_rule({3'd2, 3'd0, 3'd0, 3'd4}, 3'd4, 16'h6666, 2'b01, "R6", 0);
    run_rule({3'd1, 3'd0, 3'd0, 3'd7}, 3'd4, 16'h7777, 2'b11, "R8", 1);

    // constrained random rules
    for (int n = 0; n < 30; n++) begin
      logic [11:0] idx;
      logic [2:0]  num;
      num = 3'($urandom_range(1, 4));
      for (int k = 0; k < 4; k++)
        idx[k*3 +: 3] = ($urandom_range(0, 9) < 4) ? 3'd0 : 3'($urandom_range(1, 7));
      if (idx == 12'd0 && num == 3'd4) idx[2:0] = 3'd1;
      run_rule(idx, num, 16'($urandom), 2'($urandom_range(1, 3)), "", 0);
    end

    if (!finished) begin
      finished = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule